// File: doc/BRIEF.md
# Configurable SPI Master Exchange Engine

This block is a serial-peripheral master that trades one word with a slave device in full duplex. The host loads a transmit word and pulses a start strobe. The engine then selects the slave by pulling its own active-low select line, toggles the serial clock, and moves one bit out and one bit in on each clock. When the last bit has been captured, it returns the received word together with a single-cycle done pulse.

The host can change three settings at run time: the word length (8, 16 or 32 bits), the clock idle level and sampling phase, and a divider that sets the serial clock rate. A setting written during an exchange is kept aside and applied once the engine goes idle again. A keep-selected flag, given with the start strobe, holds the select line low after the word ends. Several words can therefore form one gapless burst. The burst ends with a word that is started without the flag.

Top module: `spi_xchg_master`

## Requirements
- R1: Each exchange is full duplex and most-significant bit first. The slave receives the transmit word, and `rx_word` returns the slave's word. Both are delivered with `done`.
- R2: `cfg_size` takes the literal values 8, 16 or 32 when `cfg_wr` is high. Any other value leaves the word length as it was. After reset the word length is 8.
- R3: At 8 or 16 bits, only the low 8 or 16 bits of `tx_word` are sent. Bits of `rx_word` above the word length read zero.
- R4: While idle, `sck` rests at the level of `cfg_cpol` (0 rests low, 1 rests high). After reset `sck` is low.
- R5: With `cfg_cpha`=0, both sides sample on the first clock edge of each bit. With `cfg_cpha`=1, they sample on the second edge.
- R6: `ss_n` is low during every exchange. The first `sck` edge comes at least one half-period after the exchange starts. `ss_n` returns high after the last word of a transfer.
- R7: A word started with `keep_sel`=1 leaves `ss_n` low afterwards. `ss_n` then stays low, with no high gap, until a word started with `keep_sel`=0 completes.
- R8: `busy` is high from the cycle after an accepted start until `done`. A `start` seen while busy is ignored and produces no extra exchange.
- R9: Each `sck` half-period lasts `cfg_div`+1 clock cycles.
- R10: Configuration written while busy, or while a burst holds `ss_n` low, takes effect only after the engine is idle and deselected.
- R11: `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_size | input | 6 | Requested word length (8, 16, 32) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_div | input | DIV_W | Half-period divider |
| tx_word | input | 32 | Word to transmit |
| keep_sel | input | 1 | Keep slave selected after this word |
| start | input | 1 | Start strobe |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange complete pulse |
| rx_word | output | 32 | Received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A behavioural slave shifts its own word back while it records the serial input. The exchange runs under all four polarity and phase combinations and at all three word lengths, with transmit and slave words whose upper bits are set. That pattern shows whether the length masking and the bit order are right, and whether the sampling edge matches the mode. Other runs try an illegal length after a legal one, a second start strobe in the middle of a word, and a configuration write in the middle of a word. These separate held-back settings from settings applied at once. A three-word burst with the keep flag shows whether select gaps appear between words. An edge-spacing monitor compares every half-period with the divider.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SZ_W   = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } xchg_state_e;

    // one-hot length: bit0 = 8, bit1 = 16, bit2 = 32
    typedef logic [2:0] size_oh_t;

    typedef struct packed {
        size_oh_t size;
        logic     cpol;
        logic     cpha;
    } mode_t;

    function automatic logic [SZ_W-1:0] size_bits(input size_oh_t s);
        logic [SZ_W-1:0] r;
        unique case (1'b1)
            s[2]:    r = SZ_W'(32);
            s[1]:    r = SZ_W'(16);
            default: r = SZ_W'(8);
        endcase
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] word_mask(input size_oh_t s);
        logic [WORD_W-1:0] m;
        unique case (1'b1)
            s[2]:    m = {WORD_W{1'b1}};
            s[1]:    m = WORD_W'(32'h0000_FFFF);
            default: m = WORD_W'(32'h0000_00FF);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/spi_cfg_hold.sv
module spi_cfg_hold
    import spi_xchg_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SZ_W-1:0]  size_in,
    input  logic             cpol_in,
    input  logic             cpha_in,
    input  logic [DIV_W-1:0] div_in,
    input  logic             busy,
    input  logic             ss_n,
    input  logic             start,
    output mode_t            act_mode,
    output logic [DIV_W-1:0] act_div
);

    typedef struct packed {
        mode_t            pend;
        logic [DIV_W-1:0] pend_div;
        mode_t            act;
        logic [DIV_W-1:0] act_div;
    } hold_t;

    hold_t q, d;
    logic  apply;

    always_comb begin
        d     = q;
        apply = !busy && ss_n && !start;
        if (wr) begin
            d.pend.cpol = cpol_in;
            d.pend.cpha = cpha_in;
            d.pend_div  = div_in;
            case (size_in)
                SZ_W'(8):  d.pend.size = 3'b001;
                SZ_W'(16): d.pend.size = 3'b010;
                SZ_W'(32): d.pend.size = 3'b100;
                default:   d.pend.size = q.pend.size;
            endcase
        end
        if (apply) begin
            d.act     = q.pend;
            d.act_div = q.pend_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pend: '{size: 3'b001, cpol: 1'b0, cpha: 1'b0}, pend_div: '0,
                   act:  '{size: 3'b001, cpol: 1'b0, cpha: 1'b0}, act_div:  '0};
        end else begin
            q <= d;
        end
    end

    assign act_mode = q.act;
    assign act_div  = q.act_div;

    // R2
    size_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.act.size) == 1);

    // R10
    cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(q.act) && $stable(q.act_div)));

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             at_end;

    always_comb begin
        at_end = (cnt_q == div);
        if (!run || at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && at_end;

endmodule

// File: rtl/spi_xchg_core.sv
module spi_xchg_core
    import spi_xchg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              keep_sel,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    input  logic              tick,
    input  mode_t             mode,
    output logic              run,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);

    typedef struct packed {
        xchg_state_e       st;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] rx_out;
        logic [SZ_W-1:0]   edg;
        logic              sck;
        logic              mosi;
        logic              ss_n;
        logic              keep;
        logic              done;
    } core_t;

    core_t           q, d;
    logic [SZ_W-1:0] nb;
    logic [SZ_W:0]   last_edge;
    logic            sample_e;

    always_comb begin
        nb        = size_bits(mode.size);
        last_edge = {nb, 1'b0} - {{SZ_W{1'b0}}, 1'b1};
        // even edge count = leading edge; phase 0 samples there
        sample_e  = ~q.edg[0] ^ mode.cpha;
        d         = q;
        d.done    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.sck = mode.cpol;
                if (start) begin
                    d.st   = ST_LEAD;
                    d.ss_n = 1'b0;
                    d.keep = keep_sel;
                    d.edg  = '0;
                    d.rx   = '0;
                    d.sh   = tx_word & word_mask(mode.size);
                    if (!mode.cpha) begin
                        d.mosi = d.sh[nb - SZ_W'(1)];
                        d.sh   = d.sh << 1;
                    end
                end
            end
            ST_LEAD: begin
                if (tick) d.st = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick) begin
                    d.sck = ~q.sck;
                    d.edg = q.edg + SZ_W'(1);
                    if (sample_e) begin
                        d.rx = {q.rx[WORD_W-2:0], miso};
                    end else begin
                        d.mosi = q.sh[nb - SZ_W'(1)];
                        d.sh   = q.sh << 1;
                    end
                    if ({1'b0, q.edg} == last_edge) d.st = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.rx_out = q.rx;
                    d.ss_n   = ~q.keep;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sh: '0, rx: '0, rx_out: '0, edg: '0,
                   sck: 1'b0, mosi: 1'b0, ss_n: 1'b1, keep: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign run     = (q.st != ST_IDLE);
    assign sck     = q.sck;
    assign mosi    = q.mosi;
    assign ss_n    = q.ss_n;
    assign done    = q.done;
    assign rx_word = q.rx_out;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R6
    ss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> !q.ss_n);

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && $past(q.st) == ST_IDLE) |-> (q.sck == $past(mode.cpol)));

    // R9
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && !tick) |=> $stable(q.sck));

endmodule

// File: rtl/spi_xchg_master.sv
module spi_xchg_master
    import spi_xchg_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              keep_sel,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);

    mode_t            mode;
    logic [DIV_W-1:0] div;
    logic             run;
    logic             tick;

    spi_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .size_in  (cfg_size),
        .cpol_in  (cfg_cpol),
        .cpha_in  (cfg_cpha),
        .div_in   (cfg_div),
        .busy     (run),
        .ss_n     (ss_n),
        .start    (start),
        .act_mode (mode),
        .act_div  (div)
    );

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .tick  (tick)
    );

    spi_xchg_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .keep_sel (keep_sel),
        .tx_word  (tx_word),
        .miso     (miso),
        .tick     (tick),
        .mode     (mode),
        .run      (run),
        .sck      (sck),
        .mosi     (mosi),
        .ss_n     (ss_n),
        .done     (done),
        .rx_word  (rx_word)
    );

    assign busy = run;

endmodule

// File: tb/sim_spi_xchg_master.sv
module sim_spi_xchg_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_size = 6'd8;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic [31:0] tx_word = '0;
    logic        keep_sel = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, sck, mosi, ss_n;
    logic        miso = 1'b0;
    logic [31:0] rx_word;

    always #2 clk = ~clk;

    spi_xchg_master #(.DIV_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size(cfg_size),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div(cfg_div),
        .tx_word(tx_word), .keep_sel(keep_sel), .start(start),
        .busy(busy), .done(done), .rx_word(rx_word), .sck(sck),
        .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench view of the active mode
    int tb_n = 8;
    bit tb_cpol = 0;
    bit tb_cpha = 0;
    int tb_div = 0;

    function automatic logic [31:0] msk(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    // behavioural slave
    logic [31:0] sl_word = '0;
    logic [31:0] sl_sh = '0;
    logic [31:0] sl_rx = '0;
    int          sl_bits = 0;

    always @(posedge busy) begin
        sl_rx   = '0;
        sl_bits = 0;
        sl_sh   = sl_word & msk(tb_n);
        if (!tb_cpha) begin
            miso  = sl_sh[tb_n-1];
            sl_sh = sl_sh << 1;
        end
    end

    always @(sck) begin
        if (busy && !ss_n) begin
            if ((sck != tb_cpol) ^ tb_cpha) begin
                sl_rx = {sl_rx[30:0], mosi};
                sl_bits++;
            end else begin
                miso  = sl_sh[tb_n-1];
                sl_sh = sl_sh << 1;
            end
        end
    end

    // scoreboard queues
    logic [31:0] q_rx[$];
    logic [31:0] q_sl[$];
    int          q_n[$];

    int  cyc = 0, last_edge_cyc = 0, start_cyc = 0;
    int  hp_bad = 0, lead_bad = 0, ss_rise = 0;
    bit  seen = 0, last_busy = 0, last_sck = 0, last_ss = 1, chk_fall = 0;

    // monitor
    always @(negedge clk) begin
        cyc++;
        if (chk_fall) begin
            chk(" R11 done one cycle", {63'd0, done}, 64'd0);
            chk_fall = 0;
        end
        if (busy && !last_busy) begin
            seen = 0;
            start_cyc = cyc;
        end
        if (sck != last_sck && busy) begin
            if (!seen) begin
                if (cyc - start_cyc < tb_div + 1) lead_bad++;
            end else if (cyc - last_edge_cyc != tb_div + 1) begin
                hp_bad++;
            end
            seen = 1;
            last_edge_cyc = cyc;
        end
        if (ss_n && !last_ss) ss_rise++;
        last_sck  = sck;
        last_busy = busy;
        last_ss   = ss_n;
        if (done) begin
            if (q_rx.size() == 0) begin
                chk("R8 unexpected done", 64'd1, 64'd0);
            end else begin
                logic [31:0] e_rx, e_sl;
                int          e_n;
                e_rx = q_rx.pop_front();
                e_sl = q_sl.pop_front();
                e_n  = q_n.pop_front();
                chk("R1/R3 rx_word", {32'd0, rx_word}, {32'd0, e_rx});
                chk("R1/R5 slave got", {32'd0, sl_rx}, {32'd0, e_sl});
                chk("R2 bit count", 64'(sl_bits), 64'(e_n));
                chk("R9 half-period", 64'(hp_bad), 64'd0);
                chk("R6 select lead", 64'(lead_bad), 64'd0);
                hp_bad   = 0;
                lead_bad = 0;
                chk_fall = 1;
            end
        end
    end

    task automatic set_cfg(input int sz, input bit pol, input bit pha, input int dv);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_size = 6'(sz);
        cfg_cpol = pol;
        cfg_cpha = pha;
        cfg_div  = 8'(dv);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sz == 8 || sz == 16 || sz == 32) tb_n = sz;
        tb_cpol = pol;
        tb_cpha = pha;
        tb_div  = dv;
        repeat (3) @(negedge clk);
    endtask

    // mid: 0 none, 1 stray start, 2 config write mid-word
    task automatic xfer(input logic [31:0] t, input logic [31:0] s, input bit k, input int mid);
        q_rx.push_back(s & msk(tb_n));
        q_sl.push_back(t & msk(tb_n));
        q_n.push_back(tb_n);
        sl_word  = s;
        @(negedge clk);
        tx_word  = t;
        keep_sel = k;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid == 1) begin
            repeat (5) @(negedge clk);
            chk("R8 busy mid-word", {63'd0, busy}, 64'd1);
            tx_word = ~t;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end else if (mid == 2) begin
            repeat (5) @(negedge clk);
            cfg_wr   = 1'b1;
            cfg_size = 6'd32;
            cfg_cpol = ~tb_cpol;
            cfg_cpha = tb_cpha;
            cfg_div  = 8'(tb_div);
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R4 reset sck low", {63'd0, sck}, 64'd0);
        chk("R6 reset ss_n high", {63'd0, ss_n}, 64'd1);
        chk("R8 reset busy low", {63'd0, busy}, 64'd0);
        chk("R11 reset done low", {63'd0, done}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 reset length 8, R3 masking, mode 0
        xfer(32'hCAFE_1234, 32'hFFFF_FF5A, 1'b0, 0);
        // R5 phase 1, 16 bits
        set_cfg(16, 0, 1, 2);
        xfer(32'h1357_9BDF, 32'h7777_A5F0, 1'b0, 0);
        // R4 idle high
        set_cfg(32, 1, 0, 1);
        chk("R4 idle level cpol1", {63'd0, sck}, 64'd1);
        xfer(32'h8000_0001, 32'hDEAD_BEEF, 1'b0, 0);
        set_cfg(32, 1, 1, 3);
        xfer(32'h0F0F_55AA, 32'h1234_5678, 1'b0, 0);
        repeat (3) @(negedge clk);
        chk("R6 ss_n high after word", {63'd0, ss_n}, 64'd1);
        // R2 illegal length ignored
        set_cfg(16, 0, 0, 0);
        set_cfg(12, 0, 0, 0);
        xfer(32'hAAAA_C3C3, 32'h5555_3C3C, 1'b0, 0);
        // R8 stray start ignored
        set_cfg(8, 0, 0, 1);
        xfer(32'h0000_0096, 32'h0000_0069, 1'b0, 1);
        repeat (30) @(negedge clk);
        chk("R8 no second exchange", {63'd0, busy}, 64'd0);
        chk("R8 queue drained", 64'(q_rx.size()), 64'd0);
        // R7 burst
        begin
            int r0;
            set_cfg(8, 0, 1, 1);
            r0 = ss_rise;
            xfer(32'h11, 32'hE1, 1'b1, 0);
            repeat (4) @(negedge clk);
            chk("R7 held low between words", {63'd0, ss_n}, 64'd0);
            xfer(32'h22, 32'hD2, 1'b1, 0);
            xfer(32'h33, 32'hC3, 1'b0, 0);
            repeat (4) @(negedge clk);
            chk("R7 single release", 64'(ss_rise - r0), 64'd1);
            chk("R7 released after last", {63'd0, ss_n}, 64'd1);
        end
        // R10 config written mid-word is deferred
        set_cfg(8, 0, 0, 2);
        xfer(32'hFFFF_FF81, 32'hFFFF_FF7E, 1'b0, 2);
        tb_n    = 32;
        tb_cpol = 1;
        repeat (4) @(negedge clk);
        chk("R10 new idle level applied", {63'd0, sck}, 64'd1);
        xfer(32'hA1B2_C3D4, 32'h0102_0304, 1'b0, 0);
        // R9 larger divider
        set_cfg(16, 0, 1, 7);
        xfer(32'h0000_F00D, 32'h0000_BEAD, 1'b0, 0);
        repeat (5) @(negedge clk);
        chk("R1 all results consumed", 64'(q_rx.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule